// File: doc/BRIEF.md
# Code Module Header Validator

This block checks the header of a code module that already sits in on-chip memory. From the same header it also derives the execution state the processor enters with. A single-cycle `start_i` pulse latches the module base and size, the header length (counted in 4-byte words), the scratch size, the descriptor-table pointer and limit, the segment selector, the normal and error entry offsets, the control word and the snoop-hit flag. Later changes on these inputs have no effect on the run.

The validator applies one rule per clock cycle, in a fixed order. The first rule that fails ends the run. That rule's fault code is reported with a one-cycle `done_o` strobe. If every rule holds, `done_o` comes with `pass_o` set and with the derived state: the entry address, the descriptor-table base and limit, the code and data selectors, and the flat segment attributes. A shutdown path or a launch sequencer reads the result at the strobe.

Below, the "floor" is the header length times 4 plus the scratch size. All offsets are relative to the module base.

Top module: `modhdr_validator`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o` and `pass_o` are 0. `fault_o` and every state output are 0.
- R2: When idle, a `start_i` sample begins a run and `busy_o` rises. The rules are tried one per cycle in this order: snoop (code 1), control reserved (2), table bounds (3), entry bounds (4), selector range (5), selector attributes (6). `done_o` pulses for one cycle, k cycles after the start edge, where k is the position of the first failing rule, or 6 on a pass. `busy_o` falls on the same edge. Later rules do not affect the code.
- R3: `start_i` is ignored while `busy_o` is 1. The result reflects only the inputs latched at the accepted start.
- R4: If control bit 0 is 0, control bit 1 is 1 and the snoop flag is set, the fault code is 1.
- R5: If any control bit above bit 1 is set, the fault code is 2.
- R6: If the table pointer is below the floor, or pointer plus table limit is greater than or equal to the module size, the fault code is 3.
- R7: The error entry offset is used when control bits 0 and 1 are both 1 and the snoop flag is set. Otherwise the normal entry offset is used. The entry address is the base plus the chosen offset.
- R8: If the chosen entry offset is greater than or equal to the module size, or below the floor, the fault code is 4.
- R9: If the selector is below 8, or above the table limit minus 15, the fault code is 5. A table limit below 15 always fails this rule.
- R10: If selector bit 2 (table indicator) or bits 1:0 (privilege) are nonzero, the fault code is 6.
- R11: On a pass, `pass_o` is 1 and `fault_o` is 0. The table base is the module base plus the pointer, and the table limit is the header value. The code selector is the header selector, and the data selector is that value plus 8.
- R12: On a pass, the code access rights are 9Bh and the data access rights are 93h, with segment base 0, limit FFFFFh, and G and D both 1. On a fault, all state outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin validation of the presented header |
| mod_base_i | input | ADDR_W | Module base address |
| mod_size_i | input | OFF_W | Module size in bytes |
| hdr_words_i | input | HL_W | Header length in 4-byte words |
| scratch_i | input | OFF_W | Scratch region size in bytes |
| gdt_ptr_i | input | OFF_W | Descriptor-table offset |
| gdt_lim_i | input | LIM_W | Descriptor-table limit |
| sel_i | input | SEL_W | Code segment selector |
| entry_i | input | OFF_W | Normal entry offset |
| err_entry_i | input | OFF_W | Error entry offset |
| ctrl_i | input | CTRL_W | Control word |
| snoop_hit_i | input | 1 | Modified-line snoop hit seen during load |
| busy_o | output | 1 | Rules being evaluated |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | All rules held |
| fault_o | output | 3 | Fault code, 0 on pass |
| entry_addr_o | output | ADDR_W | Entry address |
| gdt_base_o | output | ADDR_W | Descriptor-table base |
| gdt_lim_o | output | LIM_W | Descriptor-table limit |
| cs_sel_o | output | SEL_W | Code selector |
| ds_sel_o | output | SEL_W | Data selector |
| cs_ar_o | output | 8 | Code access rights |
| ds_ar_o | output | 8 | Data access rights |
| seg_base_o | output | ADDR_W | Segment base |
| seg_limit_o | output | 20 | Segment limit |
| seg_g_o | output | 1 | Granularity flag |
| seg_d_o | output | 1 | Default size flag |

## Verification
On every cycle, the assertions check that a run never lasts more than six cycles and that the strobe is a single-cycle pulse that follows a busy cycle. At every strobe they also check that the fault code agrees with the pass flag, that a passing selector has legal attributes, that the data selector is the code selector plus 8, and that the access rights and flat segment values are correct. A faulted result must show zeroed state. Which rule wins when several fail, the exact strobe cycle, the entry-point choice, the bounds boundaries and the ignoring of a start during a run can only be shown by the bench's scenarios. The bench compares these against its behavioural model.

// File: rtl/modhdr_pkg.sv
package modhdr_pkg;

    localparam int NUM_RULES = 6;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_SNOOP    = 3'd1,
        FLT_CTRL     = 3'd2,
        FLT_GDT      = 3'd3,
        FLT_ENTRY    = 3'd4,
        FLT_SEL_RNG  = 3'd5,
        FLT_SEL_ATTR = 3'd6
    } fault_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic [7:0]  ar;
        logic [19:0] limit;
        logic        gran;
        logic        dsize;
    } seg_attr_t;

    localparam logic [7:0]  CODE_AR   = 8'h9B;
    localparam logic [7:0]  DATA_AR   = 8'h93;
    localparam logic [19:0] FLAT_LIM  = 20'hFFFFF;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic fault_e rule_fault(input int idx);
        return fault_e'(idx + 1);
    endfunction

    function automatic seg_attr_t flat_attr(input logic [7:0] rights);
        seg_attr_t a;
        a.ar    = rights;
        a.limit = FLAT_LIM;
        a.gran  = 1'b1;
        a.dsize = 1'b1;
        return a;
    endfunction

endpackage

// File: rtl/modhdr_rules.sv
module modhdr_rules
    import modhdr_pkg::*;
#(
    parameter int OFF_W  = 32,
    parameter int HL_W   = 16,
    parameter int LIM_W  = 16,
    parameter int SEL_W  = 16,
    parameter int CTRL_W = 16
) (
    input  logic [OFF_W-1:0]     size_i,
    input  logic [HL_W-1:0]      hdr_words_i,
    input  logic [OFF_W-1:0]     scratch_i,
    input  logic [OFF_W-1:0]     gdt_ptr_i,
    input  logic [LIM_W-1:0]     gdt_lim_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [OFF_W-1:0]     entry_i,
    input  logic [OFF_W-1:0]     err_entry_i,
    input  logic [CTRL_W-1:0]    ctrl_i,
    input  logic                 snoop_i,
    output logic                 use_err_o,
    output logic [NUM_RULES-1:0] fail_o
);

    localparam int CW = maxi(maxi(OFF_W, HL_W + 2), maxi(LIM_W, SEL_W)) + 2;

    logic [CW-1:0] floor_w;
    logic [CW-1:0] size_w;
    logic [CW-1:0] ptr_w;
    logic [CW-1:0] tbl_end_w;
    logic [CW-1:0] off_w;
    logic [CW-1:0] sel_w;
    logic [CW-1:0] lim_w;
    logic [OFF_W-1:0] chosen_off;
    logic          rsvd_set;

    generate
        if (CTRL_W > 2) begin : g_rsvd
            assign rsvd_set = |ctrl_i[CTRL_W-1:2];
        end else begin : g_no_rsvd
            assign rsvd_set = 1'b0;
        end
    endgenerate

    always_comb begin
        use_err_o  = ctrl_i[0] & ctrl_i[1] & snoop_i;
        chosen_off = use_err_o ? err_entry_i : entry_i;
        floor_w    = CW'({hdr_words_i, 2'b00}) + CW'(scratch_i);
        size_w     = CW'(size_i);
        ptr_w      = CW'(gdt_ptr_i);
        lim_w      = CW'(gdt_lim_i);
        tbl_end_w  = ptr_w + lim_w;
        off_w      = CW'(chosen_off);
        sel_w      = CW'(sel_i);

        fail_o[0] = ~ctrl_i[0] & ctrl_i[1] & snoop_i;
        fail_o[1] = rsvd_set;
        fail_o[2] = (ptr_w < floor_w) || (tbl_end_w >= size_w);
        fail_o[3] = (off_w >= size_w) || (off_w < floor_w);
        fail_o[4] = (sel_w < CW'(8)) || ((sel_w + CW'(15)) > lim_w);
        fail_o[5] = sel_i[2] | (|sel_i[1:0]);
    end

endmodule

// File: rtl/modhdr_seq.sv
module modhdr_seq
    import modhdr_pkg::*;
#(
    parameter int NRULE = NUM_RULES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NRULE-1:0] fail_i,
    output logic             cap_o,
    output logic             busy_o,
    output logic             fin_o,
    output fault_e           fin_code_o
);

    localparam int IW = (NRULE > 1) ? $clog2(NRULE) : 1;
    localparam logic [IW-1:0] LAST = IW'(NRULE - 1);

    seq_state_e     state_q;
    logic [IW-1:0]  idx_q;
    logic           cur_fail;

    always_comb begin
        cur_fail = 1'b0;
        for (int i = 0; i < NRULE; i++) begin
            if (idx_q == IW'(i)) cur_fail = fail_i[i];
        end
    end

    always_comb begin
        cap_o      = (state_q == SQ_IDLE) && start_i;
        busy_o     = (state_q == SQ_RUN);
        fin_o      = 1'b0;
        fin_code_o = FLT_NONE;
        if (state_q == SQ_RUN) begin
            if (cur_fail) begin
                fin_o      = 1'b1;
                fin_code_o = rule_fault(int'(idx_q));
            end else if (idx_q == LAST) begin
                fin_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
        end else if (cap_o) begin
            state_q <= SQ_RUN;
            idx_q   <= '0;
        end else if (fin_o) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
        end else if (busy_o) begin
            idx_q <= idx_q + IW'(1);
        end
    end

endmodule

// File: rtl/modhdr_state.sv
module modhdr_state
    import modhdr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 32,
    parameter int SEL_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  gdt_ptr_i,
    input  logic [OFF_W-1:0]  entry_i,
    input  logic [OFF_W-1:0]  err_entry_i,
    input  logic              use_err_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [ADDR_W-1:0] entry_addr_o,
    output logic [ADDR_W-1:0] gdt_base_o,
    output logic [SEL_W-1:0]  cs_o,
    output logic [SEL_W-1:0]  ds_o,
    output seg_attr_t         cs_attr_o,
    output seg_attr_t         ds_attr_o
);

    always_comb begin
        entry_addr_o = base_i + ADDR_W'(use_err_i ? err_entry_i : entry_i);
        gdt_base_o   = base_i + ADDR_W'(gdt_ptr_i);
        cs_o         = sel_i;
        ds_o         = sel_i + SEL_W'(8);
        cs_attr_o    = flat_attr(CODE_AR);
        ds_attr_o    = flat_attr(DATA_AR);
    end

endmodule

// File: rtl/modhdr_validator.sv
module modhdr_validator
    import modhdr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 32,
    parameter int HL_W   = 16,
    parameter int LIM_W  = 16,
    parameter int SEL_W  = 16,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] mod_base_i,
    input  logic [OFF_W-1:0]  mod_size_i,
    input  logic [HL_W-1:0]   hdr_words_i,
    input  logic [OFF_W-1:0]  scratch_i,
    input  logic [OFF_W-1:0]  gdt_ptr_i,
    input  logic [LIM_W-1:0]  gdt_lim_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [OFF_W-1:0]  entry_i,
    input  logic [OFF_W-1:0]  err_entry_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              snoop_hit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [2:0]        fault_o,
    output logic [ADDR_W-1:0] entry_addr_o,
    output logic [ADDR_W-1:0] gdt_base_o,
    output logic [LIM_W-1:0]  gdt_lim_o,
    output logic [SEL_W-1:0]  cs_sel_o,
    output logic [SEL_W-1:0]  ds_sel_o,
    output logic [7:0]        cs_ar_o,
    output logic [7:0]        ds_ar_o,
    output logic [ADDR_W-1:0] seg_base_o,
    output logic [19:0]       seg_limit_o,
    output logic              seg_g_o,
    output logic              seg_d_o
);

    // latched header fields
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  size_q, scratch_q, ptr_q, ent_q, err_q;
    logic [HL_W-1:0]   hdr_q;
    logic [LIM_W-1:0]  lim_q;
    logic [SEL_W-1:0]  sel_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              snoop_q;

    logic                 cap;
    logic                 fin;
    fault_e               fin_code;
    logic                 use_err;
    logic [NUM_RULES-1:0] fail_vec;

    logic [ADDR_W-1:0] nx_entry, nx_gdt_base;
    logic [SEL_W-1:0]  nx_cs, nx_ds;
    seg_attr_t         nx_cs_attr, nx_ds_attr;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            size_q    <= '0;
            scratch_q <= '0;
            ptr_q     <= '0;
            ent_q     <= '0;
            err_q     <= '0;
            hdr_q     <= '0;
            lim_q     <= '0;
            sel_q     <= '0;
            ctrl_q    <= '0;
            snoop_q   <= 1'b0;
        end else if (cap) begin
            base_q    <= mod_base_i;
            size_q    <= mod_size_i;
            scratch_q <= scratch_i;
            ptr_q     <= gdt_ptr_i;
            ent_q     <= entry_i;
            err_q     <= err_entry_i;
            hdr_q     <= hdr_words_i;
            lim_q     <= gdt_lim_i;
            sel_q     <= sel_i;
            ctrl_q    <= ctrl_i;
            snoop_q   <= snoop_hit_i;
        end
    end

    modhdr_rules #(
        .OFF_W(OFF_W), .HL_W(HL_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W)
    ) u_rules (
        .size_i      (size_q),
        .hdr_words_i (hdr_q),
        .scratch_i   (scratch_q),
        .gdt_ptr_i   (ptr_q),
        .gdt_lim_i   (lim_q),
        .sel_i       (sel_q),
        .entry_i     (ent_q),
        .err_entry_i (err_q),
        .ctrl_i      (ctrl_q),
        .snoop_i     (snoop_q),
        .use_err_o   (use_err),
        .fail_o      (fail_vec)
    );

    modhdr_seq #(.NRULE(NUM_RULES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .fail_i     (fail_vec),
        .cap_o      (cap),
        .busy_o     (busy_o),
        .fin_o      (fin),
        .fin_code_o (fin_code)
    );

    modhdr_state #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_state (
        .base_i       (base_q),
        .gdt_ptr_i    (ptr_q),
        .entry_i      (ent_q),
        .err_entry_i  (err_q),
        .use_err_i    (use_err),
        .sel_i        (sel_q),
        .entry_addr_o (nx_entry),
        .gdt_base_o   (nx_gdt_base),
        .cs_o         (nx_cs),
        .ds_o         (nx_ds),
        .cs_attr_o    (nx_cs_attr),
        .ds_attr_o    (nx_ds_attr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            pass_o       <= 1'b0;
            fault_o      <= '0;
            entry_addr_o <= '0;
            gdt_base_o   <= '0;
            gdt_lim_o    <= '0;
            cs_sel_o     <= '0;
            ds_sel_o     <= '0;
            cs_ar_o      <= '0;
            ds_ar_o      <= '0;
            seg_base_o   <= '0;
            seg_limit_o  <= '0;
            seg_g_o      <= 1'b0;
            seg_d_o      <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                fault_o <= fin_code;
                if (fin_code == FLT_NONE) begin
                    pass_o       <= 1'b1;
                    entry_addr_o <= nx_entry;
                    gdt_base_o   <= nx_gdt_base;
                    gdt_lim_o    <= lim_q;
                    cs_sel_o     <= nx_cs;
                    ds_sel_o     <= nx_ds;
                    cs_ar_o      <= nx_cs_attr.ar;
                    ds_ar_o      <= nx_ds_attr.ar;
                    seg_base_o   <= '0;
                    seg_limit_o  <= nx_cs_attr.limit;
                    seg_g_o      <= nx_cs_attr.gran & nx_ds_attr.gran;
                    seg_d_o      <= nx_cs_attr.dsize & nx_ds_attr.dsize;
                end else begin
                    pass_o       <= 1'b0;
                    entry_addr_o <= '0;
                    gdt_base_o   <= '0;
                    gdt_lim_o    <= '0;
                    cs_sel_o     <= '0;
                    ds_sel_o     <= '0;
                    cs_ar_o      <= '0;
                    ds_ar_o      <= '0;
                    seg_base_o   <= '0;
                    seg_limit_o  <= '0;
                    seg_g_o      <= 1'b0;
                    seg_d_o      <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/modhdr_checker.sv
module modhdr_checker #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int NRULE  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [2:0]        fault,
    input logic [ADDR_W-1:0] entry_addr,
    input logic [ADDR_W-1:0] gdt_base,
    input logic [SEL_W-1:0]  cs_sel,
    input logic [SEL_W-1:0]  ds_sel,
    input logic [7:0]        cs_ar,
    input logic [7:0]        ds_ar,
    input logic [19:0]       seg_limit,
    input logic              seg_g,
    input logic              seg_d
);

    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 8'd1;
    end

    assert_run_len_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < 8'(NRULE)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_code_match_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ? (fault == 3'd0) : ((fault != 3'd0) && (fault <= 3'd6))));

    assert_ds_offset_R11: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (ds_sel == cs_sel + SEL_W'(8)));

    assert_sel_attr_R10: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (cs_sel[2:0] == 3'b000));

    assert_sel_floor_R9: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (cs_sel >= SEL_W'(8)));

    assert_flat_attr_R12: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (cs_ar == 8'h9B && ds_ar == 8'h93 &&
                            seg_limit == 20'hFFFFF && seg_g && seg_d));

    assert_fault_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> (entry_addr == '0 && gdt_base == '0 &&
                             cs_sel == '0 && cs_ar == 8'h00));

endmodule

bind modhdr_validator modhdr_checker #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NRULE(modhdr_pkg::NUM_RULES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy_o),
    .done       (done_o),
    .pass       (pass_o),
    .fault      (fault_o),
    .entry_addr (entry_addr_o),
    .gdt_base   (gdt_base_o),
    .cs_sel     (cs_sel_o),
    .ds_sel     (ds_sel_o),
    .cs_ar      (cs_ar_o),
    .ds_ar      (ds_ar_o),
    .seg_limit  (seg_limit_o),
    .seg_g      (seg_g_o),
    .seg_d      (seg_d_o)
);

// File: tb/tb_modhdr_validator.sv
`timescale 1ns/1ps
module tb_modhdr_validator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base, size, scratch, ptr, ent, errent;
    logic [15:0] hdr, lim, sel, ctrl;
    logic        snoop;

    logic        busy_o, done_o, pass_o, seg_g_o, seg_d_o;
    logic [2:0]  fault_o;
    logic [31:0] entry_addr_o, gdt_base_o, seg_base_o;
    logic [15:0] gdt_lim_o, cs_sel_o, ds_sel_o;
    logic [7:0]  cs_ar_o, ds_ar_o;
    logic [19:0] seg_limit_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    modhdr_validator dut (
        .clk(clk), .rst(rst), .start_i(start),
        .mod_base_i(base), .mod_size_i(size), .hdr_words_i(hdr),
        .scratch_i(scratch), .gdt_ptr_i(ptr), .gdt_lim_i(lim), .sel_i(sel),
        .entry_i(ent), .err_entry_i(errent), .ctrl_i(ctrl), .snoop_hit_i(snoop),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fault_o(fault_o),
        .entry_addr_o(entry_addr_o), .gdt_base_o(gdt_base_o), .gdt_lim_o(gdt_lim_o),
        .cs_sel_o(cs_sel_o), .ds_sel_o(ds_sel_o), .cs_ar_o(cs_ar_o), .ds_ar_o(ds_ar_o),
        .seg_base_o(seg_base_o), .seg_limit_o(seg_limit_o),
        .seg_g_o(seg_g_o), .seg_d_o(seg_d_o)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string code_tag(input int c);
        case (c)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R11";
        endcase
    endfunction

    // behavioural reference: evaluated on the latched inputs
    int     m_code, m_left;
    bit     m_busy = 0, m_done = 0;
    longint m_entry, m_gbase, m_glim, m_cs, m_ds;

    function automatic int ref_code(input longint b_size, input longint b_hdr, input longint b_scr,
                                    input longint b_ptr, input longint b_lim, input longint b_sel,
                                    input longint b_ent, input longint b_err,
                                    input logic [15:0] b_ctrl, input bit b_snoop);
        longint fl, off;
        fl = b_hdr * 4 + b_scr;
        if (!b_ctrl[0] && b_ctrl[1] && b_snoop) return 1;
        if ((b_ctrl & 16'hFFFC) != 0) return 2;
        if (b_ptr < fl || b_ptr + b_lim >= b_size) return 3;
        off = (b_ctrl[0] && b_ctrl[1] && b_snoop) ? b_err : b_ent;
        if (off >= b_size || off < fl) return 4;
        if (b_sel < 8 || b_sel + 15 > b_lim) return 5;
        if ((b_sel & 7) != 0) return 6;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                longint off;
                m_code = ref_code(size, hdr, scratch, ptr, lim, sel, ent, errent, ctrl, snoop);
                m_left = (m_code == 0) ? 6 : m_code;
                m_busy = 1;
                off = (ctrl[0] && ctrl[1] && snoop) ? errent : ent;
                if (m_code == 0) begin
                    m_entry = (longint'(base) + off) & 64'hFFFF_FFFF;
                    m_gbase = (longint'(base) + ptr) & 64'hFFFF_FFFF;
                    m_glim  = lim;
                    m_cs    = sel;
                    m_ds    = (longint'(sel) + 8) & 64'hFFFF;
                end else begin
                    m_entry = 0; m_gbase = 0; m_glim = 0; m_cs = 0; m_ds = 0;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "busy", busy_o, m_busy);
            chk("R2", "done", done_o, m_done);
            if (m_done) begin
                bit p;
                p = (m_code == 0);
                chk(code_tag(m_code), "fault", fault_o, m_code);
                chk("R11", "pass", pass_o, p);
                chk("R7", "entry", entry_addr_o, m_entry);
                chk("R11", "gdt_base", gdt_base_o, m_gbase);
                chk("R11", "gdt_lim", gdt_lim_o, m_glim);
                chk("R11", "cs", cs_sel_o, m_cs);
                chk("R11", "ds", ds_sel_o, m_ds);
                chk("R12", "cs_ar", cs_ar_o, p ? 8'h9B : 0);
                chk("R12", "ds_ar", ds_ar_o, p ? 8'h93 : 0);
                chk("R12", "seg_base", seg_base_o, 0);
                chk("R12", "seg_limit", seg_limit_o, p ? 20'hFFFFF : 0);
                chk("R12", "seg_g", seg_g_o, p);
                chk("R12", "seg_d", seg_d_o, p);
            end
        end
    end

    task automatic defaults();
        base = 32'h0010_0000; size = 32'h8000; hdr = 16'd56; scratch = 32'h200;
        ptr = 32'h400; lim = 16'h3F; sel = 16'h8; ent = 32'h1000; errent = 32'h2000;
        ctrl = 16'h0; snoop = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (done_o) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "pass", pass_o, 0);
        chk("R1", "fault", fault_o, 0);
        chk("R1", "entry", entry_addr_o, 0);
        chk("R1", "cs_ar", cs_ar_o, 0);

        defaults(); go();                                   // R11 R12 plain pass
        defaults(); ctrl = 16'h3; snoop = 1; go();          // R7 error entry
        defaults(); ctrl = 16'h1; snoop = 1; go();          // R7 bit1 clear
        defaults(); ctrl = 16'h3; snoop = 0; go();          // R7 no snoop
        defaults(); ctrl = 16'h2; snoop = 1; go();          // R4
        defaults(); ctrl = 16'h2; snoop = 0; go();          // R4 no snoop: pass
        defaults(); ctrl = 16'h4; go();                     // R5
        defaults(); ctrl = 16'h8002; snoop = 1; go();       // R2 priority: code 1
        defaults(); ptr = 32'h2DF; go();                    // R6 below floor
        defaults(); ptr = 32'h2E0; go();                    // R6 boundary pass
        defaults(); ptr = 32'h7FC0; lim = 16'h40; go();     // R6 end == size
        defaults(); ptr = 32'h7FBF; lim = 16'h40; go();     // R6 end == size-1
        defaults(); ent = 32'h8000; go();                   // R8 at size
        defaults(); ent = 32'h7FFF; go();                   // R8 boundary pass
        defaults(); ent = 32'h2DF; go();                    // R8 below floor
        defaults(); ctrl = 16'h3; snoop = 1; errent = 32'h9000; go(); // R8 via error entry
        defaults(); errent = 32'h9000; go();                // R7 unused error entry
        defaults(); sel = 16'h0; go();                      // R9 below 8
        defaults(); sel = 16'h30; go();                     // R9 top boundary pass
        defaults(); sel = 16'h38; go();                     // R9 above
        defaults(); lim = 16'h0A; ptr = 32'h300; go();      // R9 small limit
        defaults(); sel = 16'h0C; go();                     // R10 table bit
        defaults(); sel = 16'h0B; go();                     // R10 privilege
        defaults(); ctrl = 16'h10; sel = 16'h3; go();       // R2 first failure wins

        // R3: start held during a run with changed fields
        defaults();
        @(negedge clk); start = 1'b1;
        @(negedge clk); sel = 16'h0C; ent = 32'h1100;
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (done_o) break;
            @(negedge clk);
        end
        chk("R3", "entry_first_set", entry_addr_o, 32'h0010_1000);
        chk("R3", "fault_first_set", fault_o, 0);
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule